// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block pulls outgoing frames from a ring of transmit descriptors held in shared memory. When kicked, it walks the ring from its current position. For each descriptor it owns, it copies the referenced buffer bytes into a local gather store. Once a descriptor marked as the last of a frame has been consumed, it streams the collected frame out on a byte stream with first and last markers and a valid/ready handshake.

Ownership goes back to the host in two steps. A continuation descriptor is released as soon as its buffer has been read. The descriptor that opened the frame is released only after the frame has left the block, and that release comes with a one-cycle completion pulse. A scan handles a limited number of frames and stops early at the first frame it cannot send. If a chain is cut short by a descriptor the host still holds, the frame is dropped and reported as an underflow. A stop command ends any scan at once and rewinds the ring position.

Memory is reached through a word-addressed request port. The request is held until a one-cycle acknowledge arrives, and read data is returned with that acknowledge.

Top module: `tx_ring_engine`

## Requirements
- R1: After reset the block makes no memory request, drives no stream data and raises neither tx_done nor tx_underflow.
- R2: A kick makes no memory access when tx_on is low or ring_base is zero.
- R3: Descriptor n sits at byte address ring_base + 16·n. Word 0 is the buffer byte address. Word 1 holds owned-by-engine at bit 31, first-of-frame at bit 25, last-of-frame at bit 24, and in bits 11:0 the byte count as a negative 12-bit value (count = (4096 − field) mod 4096).
- R4: A frame carries, in order, the buffer bytes of each descriptor from the opening one through the one with last-of-frame set. out_sop marks its first byte and out_eop its last. The data and markers stay steady while out_valid is high and out_ready is low.
- R5: Each descriptor without first-of-frame has word 1 written back with bit 31 cleared and every other bit unchanged, right after its buffer is read and before the next descriptor is fetched.
- R6: After a frame has been streamed, word 1 of its opening descriptor is written back with bit 31 cleared and tx_done pulses for one cycle. A frame of zero bytes streams nothing but is still released and still pulses tx_done.
- R7: If a following descriptor is not owned before last-of-frame is reached, tx_underflow pulses once. No byte of that frame is streamed, tx_done stays low, the opening descriptor stays owned and the scan ends.
- R8: The ring position moves past every consumed descriptor. It wraps to 0 after entry 2^ring_log2 − 1, with the ring capped at 512 entries, and it carries over from one scan to the next.
- R9: A scan ends when the next opening descriptor is not owned, or after 16 frames, whichever comes first.
- R10: A frame holds at most 2048 bytes. Bytes beyond that are read and dropped, and the frame is streamed with its first 2048 bytes.
- R11: Stop aborts any scan and any stream in progress. From the next cycle the block is idle, and the ring position returns to 0.
- R12: A memory request keeps its address, direction and write data unchanged until mem_ack is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ring_base | input | 32 | Byte address of descriptor 0 |
| ring_log2 | input | 4 | log2 of ring entries (capped at 9) |
| tx_on | input | 1 | Transmit enabled |
| kick | input | 1 | Start a scan pass |
| stop | input | 1 | Abort and rewind |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 30 | Word address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request completed |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| out_data | output | 8 | Frame byte |
| out_valid | output | 1 | Frame byte valid |
| out_sop | output | 1 | First byte of frame |
| out_eop | output | 1 | Last byte of frame |
| out_ready | input | 1 | Sink accepts byte |
| tx_done | output | 1 | Frame sent and released (pulse) |
| tx_underflow | output | 1 | Frame abandoned (pulse) |

## Verification
Some properties are checked on every cycle by assertions:
- a memory request stays stable until acknowledged;
- a stalled stream byte holds;
- every write-back clears the ownership bit;
- stop empties the block by the next cycle;
- completion, underflow and streaming never overlap;
- the ring position stays within the ring;
- the gather count never exceeds its capacity;
- the sixteenth completion ends the scan.

Other behaviour only the bench scenarios can show:
- the exact byte order across chained and unaligned buffers;
- which descriptors are released and when;
- the wrap of the ring position and its carry-over between scans;
- truncation at the buffer size;
- the restart from entry 0 after a stop.

// File: rtl/tx_ring_pkg.sv
package tx_ring_pkg;

  typedef enum logic [2:0] {
    S_IDLE,   // waiting for a kick
    S_FLAGS,  // reading descriptor word 1
    S_BADDR,  // reading descriptor word 0
    S_FETCH,  // reading one buffer word
    S_PICK,   // moving bytes of that word into the gather store
    S_RELC,   // releasing a continuation descriptor
    S_SEND,   // streaming the gathered frame
    S_RELF    // releasing the opening descriptor
  } txr_state_e;

  localparam int unsigned FLG_OWN = 31;
  localparam int unsigned FLG_SOP = 25;
  localparam int unsigned FLG_EOP = 24;
  localparam int unsigned LEN_W   = 12;

  // buffer length field holds the negated byte count
  function automatic logic [LEN_W-1:0] field_to_bytes(input logic [LEN_W-1:0] f);
    return ~f + 12'd1;
  endfunction

endpackage

// File: rtl/tx_ring_index.sv
module tx_ring_index #(
  parameter int unsigned MAX_LOG2 = 9
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [3:0]          size_log2,
  input  logic                clear,
  input  logic                advance,
  output logic [MAX_LOG2-1:0] pos
);

  localparam logic [3:0] LOG2_CAP = 4'(MAX_LOG2);

  logic [MAX_LOG2:0]   ring_size;
  logic [MAX_LOG2-1:0] pos_q, pos_d;

  always_comb begin
    if (size_log2 >= LOG2_CAP) ring_size = (MAX_LOG2+1)'(1) << LOG2_CAP;
    else                       ring_size = (MAX_LOG2+1)'(1) << size_log2;
  end

  always_comb begin
    pos_d = pos_q;
    if (clear) begin
      pos_d = '0;
    end else if (advance) begin
      if ({1'b0, pos_q} + (MAX_LOG2+1)'(1) == ring_size) pos_d = '0;
      else                                               pos_d = pos_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pos_q <= '0;
    else        pos_q <= pos_d;
  end

  assign pos = pos_q;

  // R8
  idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(size_log2) && $past({1'b0, pos_q} < ring_size)) |-> ({1'b0, pos_q} < ring_size));

endmodule

// File: rtl/tx_gather_buf.sv
module tx_gather_buf #(
  parameter int unsigned DEPTH = 2048,
  localparam int unsigned CW = $clog2(DEPTH + 1),
  localparam int unsigned PW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          wr_en,
  input  logic [7:0]    wr_byte,
  input  logic          start,
  input  logic          out_ready,
  output logic          out_valid,
  output logic [7:0]    out_data,
  output logic          out_sop,
  output logic          out_eop,
  output logic [CW-1:0] cnt,
  output logic          last_xfer
);

  logic [7:0]    store [DEPTH];
  logic [CW-1:0] cnt_q, cnt_d, rd_q, rd_d;
  logic          snd_q, snd_d;
  logic          wr_ok;

  assign wr_ok     = wr_en && (cnt_q != CW'(DEPTH));
  assign out_valid = snd_q;
  assign out_data  = store[rd_q[PW-1:0]];
  assign out_sop   = (rd_q == '0);
  assign out_eop   = (rd_q == cnt_q - CW'(1));
  assign last_xfer = snd_q && out_ready && out_eop;
  assign cnt       = cnt_q;

  always_comb begin
    cnt_d = cnt_q;
    rd_d  = rd_q;
    snd_d = snd_q;
    if (clr) begin
      cnt_d = '0;
      rd_d  = '0;
      snd_d = 1'b0;
    end else begin
      if (wr_ok) cnt_d = cnt_q + CW'(1);
      if (start) begin
        snd_d = 1'b1;
        rd_d  = '0;
      end else if (snd_q && out_ready) begin
        rd_d = rd_q + CW'(1);
        if (out_eop) snd_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rd_q  <= '0;
      snd_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      rd_q  <= rd_d;
      snd_q <= snd_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_ok && !clr) store[cnt_q[PW-1:0]] <= wr_byte;
  end

  // R4
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !clr) |=> (out_valid && $stable(out_data) && $stable(out_eop) && $stable(out_sop)));

  // R10
  buf_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));

endmodule

// File: rtl/tx_ring_engine.sv
module tx_ring_engine
  import tx_ring_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned MAX_FRAMES = 16,
  parameter int unsigned RING_LOG2  = 9,
  parameter int unsigned BUF_BYTES  = 2048
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] ring_base,
  input  logic [3:0]        ring_log2,
  input  logic              tx_on,
  input  logic              kick,
  input  logic              stop,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-3:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata,
  output logic [7:0]        out_data,
  output logic              out_valid,
  output logic              out_sop,
  output logic              out_eop,
  input  logic              out_ready,
  output logic              tx_done,
  output logic              tx_underflow
);

  localparam int unsigned WA = ADDR_W - 2;
  localparam int unsigned CW = $clog2(BUF_BYTES + 1);
  localparam int unsigned FW = $clog2(MAX_FRAMES + 1);
  localparam logic [31:0] OWN_MASK = ~(32'd1 << FLG_OWN);

  txr_state_e           state_q, state_d;
  logic                 first_q, first_d;
  logic [31:0]          fflags_q, fflags_d;
  logic [31:0]          cflags_q, cflags_d;
  logic [RING_LOG2-1:0] fidx_q, fidx_d;
  logic [ADDR_W-1:0]    baddr_q, baddr_d;
  logic [LEN_W-1:0]     remain_q, remain_d, desc_bytes;
  logic [31:0]          word_q, word_d;
  logic [FW-1:0]        frm_q, frm_d;

  logic [RING_LOG2-1:0] pos;
  logic                 adv;
  logic [WA-1:0]        desc_wa, first_wa;
  logic                 gb_clr, gb_wr, gb_start, gb_last;
  logic [7:0]           gb_byte;
  logic [CW-1:0]        gb_cnt;
  logic                 nonempty;
  txr_state_e           after_rel, end_state;

  tx_ring_index #(.MAX_LOG2(RING_LOG2)) u_index (
    .clk       (clk),
    .rst_n     (rst_n),
    .size_log2 (ring_log2),
    .clear     (stop),
    .advance   (adv),
    .pos       (pos)
  );

  tx_gather_buf #(.DEPTH(BUF_BYTES)) u_gbuf (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (gb_clr),
    .wr_en     (gb_wr),
    .wr_byte   (gb_byte),
    .start     (gb_start),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_sop   (out_sop),
    .out_eop   (out_eop),
    .cnt       (gb_cnt),
    .last_xfer (gb_last)
  );

  assign desc_wa    = ring_base[ADDR_W-1:2] + WA'({pos, 2'b00});
  assign first_wa   = ring_base[ADDR_W-1:2] + WA'({fidx_q, 2'b00});
  assign desc_bytes = field_to_bytes(cflags_q[LEN_W-1:0]);
  assign gb_byte    = word_q[{baddr_q[1:0], 3'b000} +: 8];
  assign nonempty   = (gb_cnt != '0) || (state_q == S_PICK);

  // where a descriptor goes once its buffer has been consumed
  always_comb begin
    if (cflags_q[FLG_EOP]) after_rel = nonempty ? S_SEND : S_RELF;
    else                   after_rel = S_FLAGS;
    end_state = cflags_q[FLG_SOP] ? after_rel : S_RELC;
  end

  always_comb begin
    state_d      = state_q;
    first_d      = first_q;
    fflags_d     = fflags_q;
    cflags_d     = cflags_q;
    fidx_d       = fidx_q;
    baddr_d      = baddr_q;
    remain_d     = remain_q;
    word_d       = word_q;
    frm_d        = frm_q;
    mem_req      = 1'b0;
    mem_we       = 1'b0;
    mem_addr     = '0;
    mem_wdata    = '0;
    adv          = 1'b0;
    gb_clr       = stop;
    gb_wr        = 1'b0;
    tx_done      = 1'b0;
    tx_underflow = 1'b0;

    case (state_q)
      S_IDLE: begin
        if (kick && tx_on && (ring_base != '0)) begin
          state_d = S_FLAGS;
          first_d = 1'b1;
          frm_d   = '0;
        end
      end
      S_FLAGS: begin
        mem_req  = 1'b1;
        mem_addr = desc_wa + WA'(1);
        if (mem_ack) begin
          if (!mem_rdata[FLG_OWN]) begin
            state_d      = S_IDLE;
            tx_underflow = !first_q;
          end else begin
            cflags_d = mem_rdata;
            if (first_q) begin
              fflags_d = mem_rdata;
              fidx_d   = pos;
              gb_clr   = 1'b1;
            end
            state_d = S_BADDR;
          end
        end
      end
      S_BADDR: begin
        mem_req  = 1'b1;
        mem_addr = desc_wa;
        if (mem_ack) begin
          baddr_d  = mem_rdata[ADDR_W-1:0];
          remain_d = desc_bytes;
          if (desc_bytes == '0) begin
            state_d = end_state;
            adv     = cflags_q[FLG_SOP];
            if (end_state == S_FLAGS) first_d = 1'b0;
          end else begin
            state_d = S_FETCH;
          end
        end
      end
      S_FETCH: begin
        mem_req  = 1'b1;
        mem_addr = baddr_q[ADDR_W-1:2];
        if (mem_ack) begin
          word_d  = mem_rdata;
          state_d = S_PICK;
        end
      end
      S_PICK: begin
        gb_wr    = 1'b1;
        baddr_d  = baddr_q + ADDR_W'(1);
        remain_d = remain_q - LEN_W'(1);
        if (remain_q == LEN_W'(1)) begin
          state_d = end_state;
          adv     = cflags_q[FLG_SOP];
          if (end_state == S_FLAGS) first_d = 1'b0;
        end else if (baddr_q[1:0] == 2'b11) begin
          state_d = S_FETCH;
        end
      end
      S_RELC: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = desc_wa + WA'(1);
        mem_wdata = cflags_q & OWN_MASK;
        if (mem_ack) begin
          adv     = 1'b1;
          state_d = after_rel;
          if (after_rel == S_FLAGS) first_d = 1'b0;
        end
      end
      S_SEND: begin
        if (gb_last) state_d = S_RELF;
      end
      S_RELF: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = first_wa + WA'(1);
        mem_wdata = fflags_q & OWN_MASK;
        if (mem_ack) begin
          tx_done = 1'b1;
          frm_d   = frm_q + FW'(1);
          if (frm_q == FW'(MAX_FRAMES - 1)) begin
            state_d = S_IDLE;
          end else begin
            state_d = S_FLAGS;
            first_d = 1'b1;
          end
        end
      end
      default: state_d = S_IDLE;
    endcase

    if (stop) state_d = S_IDLE;
  end

  assign gb_start = (state_d == S_SEND) && (state_q != S_SEND) && !stop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      first_q  <= 1'b0;
      fflags_q <= '0;
      cflags_q <= '0;
      fidx_q   <= '0;
      baddr_q  <= '0;
      remain_q <= '0;
      word_q   <= '0;
      frm_q    <= '0;
    end else begin
      state_q  <= state_d;
      first_q  <= first_d;
      fflags_q <= fflags_d;
      cflags_q <= cflags_d;
      fidx_q   <= fidx_d;
      baddr_q  <= baddr_d;
      remain_q <= remain_d;
      word_q   <= word_d;
      frm_q    <= frm_d;
    end
  end

  // R12
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack && !stop) |=>
      (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  // R11
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> (!mem_req && !out_valid));

  // R5
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> !mem_wdata[FLG_OWN]);

  // R9
  scan_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_done && frm_q == FW'(MAX_FRAMES - 1)) |=> !mem_req);

  // R7
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tx_done, tx_underflow, out_valid}));

endmodule

// File: tb/tx_ring_engine_test.sv
module tx_ring_engine_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] ring_base;
  logic [3:0]  ring_log2;
  logic        tx_on, kick, stop;
  logic        mem_req, mem_we, mem_ack;
  logic [29:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;
  logic [7:0]  out_data;
  logic        out_valid, out_sop, out_eop, out_ready;
  logic        tx_done, tx_underflow;

  int checks = 0;
  int fails  = 0;
  int done_cnt = 0;
  int uf_cnt = 0;
  int cyc = 0;
  int ready_mode = 0;
  logic [31:0] mem [0:4095];
  logic [9:0]  exp_q [$];

  always #4 clk = ~clk;

  tx_ring_engine uut (
    .clk(clk), .rst_n(rst_n), .ring_base(ring_base), .ring_log2(ring_log2),
    .tx_on(tx_on), .kick(kick), .stop(stop),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .out_data(out_data), .out_valid(out_valid), .out_sop(out_sop), .out_eop(out_eop),
    .out_ready(out_ready), .tx_done(tx_done), .tx_underflow(tx_underflow)
  );

  function automatic logic [7:0] pat(int a);
    return 8'((a * 13 + (a >> 8) + 5) & 255);
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic set_desc(int base, int idx, int baddr, int len, bit own, bit sop, bit eop);
    int w;
    w = (base >> 2) + 4 * idx;
    mem[w]     = baddr;
    mem[w + 1] = {own, 5'd0, sop, eop, 12'd0, 12'(4096 - len)};
  endtask

  function automatic logic [31:0] flags_of(int base, int idx);
    return mem[(base >> 2) + 4 * idx + 1];
  endfunction

  task automatic push_seg(int addr, int len, bit fsop, bit feop);
    for (int i = 0; i < len; i++)
      exp_q.push_back({fsop && (i == 0), feop && (i == len - 1), pat(addr + i)});
  endtask

  task automatic pulse_kick();
    @(posedge clk); #1 kick = 1'b1;
    @(posedge clk); #1 kick = 1'b0;
  endtask

  task automatic pulse_stop();
    @(posedge clk); #1 stop = 1'b1;
    @(posedge clk); #1 stop = 1'b0;
  endtask

  task automatic wait_quiet();
    int q = 0;
    while (q < 12) begin
      @(negedge clk);
      if (mem_req || out_valid) q = 0;
      else q++;
    end
  endtask

  // memory responder: one access every two cycles
  initial begin
    mem_ack = 1'b0;
    mem_rdata = '0;
    forever begin
      @(posedge clk); #2;
      if (mem_ack) begin
        mem_ack = 1'b0;
      end else if (mem_req && rst_n) begin
        mem_ack = 1'b1;
        if (mem_we) mem[mem_addr[11:0]] = mem_wdata;
        else        mem_rdata = mem[mem_addr[11:0]];
      end
    end
  end

  // sink readiness
  initial begin
    out_ready = 1'b1;
    forever begin
      @(posedge clk); #1;
      cyc++;
      case (ready_mode)
        0: out_ready = 1'b1;
        1: out_ready = (cyc % 3) != 1;
        default: out_ready = 1'b0;
      endcase
    end
  end

  // reference comparison on every clock
  always @(negedge clk) begin
    if (rst_n) begin
      if (tx_done) done_cnt++;
      if (tx_underflow) uf_cnt++;
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R4", "unexpected stream byte", int'(out_data), -1);
        end else begin
          logic [9:0] e;
          e = exp_q.pop_front();
          chk({out_sop, out_eop, out_data} == e, "R4", "stream byte {sop,eop,data}",
              int'({out_sop, out_eop, out_data}), int'(e));
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int d0, u0, reqs;
    for (int w = 0; w < 4096; w++)
      for (int b = 0; b < 4; b++) mem[w][8*b +: 8] = pat(4 * w + b);
    rst_n = 1'b0; ring_base = '0; ring_log2 = 4'd2; tx_on = 1'b0; kick = 1'b0; stop = 1'b0;
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(!mem_req && !out_valid && !tx_done && !tx_underflow, "R1", "idle after reset",
        int'({mem_req, out_valid, tx_done, tx_underflow}), 0);

    // R2: guards
    tx_on = 1'b0; ring_base = 32'h100;
    pulse_kick();
    reqs = 0;
    for (int i = 0; i < 20; i++) begin @(negedge clk); if (mem_req) reqs++; end
    chk(reqs == 0, "R2", "requests with tx_on low", reqs, 0);
    tx_on = 1'b1; ring_base = 32'h0;
    pulse_kick();
    reqs = 0;
    for (int i = 0; i < 20; i++) begin @(negedge clk); if (mem_req) reqs++; end
    chk(reqs == 0, "R2", "requests with zero ring base", reqs, 0);

    // R3 R4 R5 R6: three-descriptor chain, unaligned buffers, backpressure
    ready_mode = 1;
    pulse_stop();
    ring_base = 32'h100; ring_log2 = 4'd2;
    set_desc(32'h100, 0, 32'h1001, 5, 1, 1, 0);
    set_desc(32'h100, 1, 32'h1203, 3, 1, 0, 0);
    set_desc(32'h100, 2, 32'h1402, 6, 1, 0, 1);
    set_desc(32'h100, 3, 32'h1500, 4, 0, 1, 1);
    push_seg(32'h1001, 5, 1, 0);
    push_seg(32'h1203, 3, 0, 0);
    push_seg(32'h1402, 6, 0, 1);
    d0 = done_cnt;
    begin
      logic [31:0] orig1;
      orig1 = flags_of(32'h100, 1);
      pulse_kick();
      wait_quiet();
      chk(done_cnt - d0 == 1, "R6", "tx_done pulses for chain", done_cnt - d0, 1);
      chk(exp_q.size() == 0, "R4", "bytes left unsent", exp_q.size(), 0);
      chk(!flags_of(32'h100, 0)[31], "R6", "opening descriptor owned", int'(flags_of(32'h100, 0)[31]), 0);
      chk(flags_of(32'h100, 1) == (orig1 & 32'h7FFF_FFFF), "R5", "continuation word 1",
          int'(flags_of(32'h100, 1)), int'(orig1 & 32'h7FFF_FFFF));
      chk(!flags_of(32'h100, 2)[31], "R5", "last descriptor owned", int'(flags_of(32'h100, 2)[31]), 0);
    end

    // R6 R8: empty frame, then wrap with carried-over position
    pulse_stop();
    ring_base = 32'h200;
    set_desc(32'h200, 0, 32'h1800, 4, 1, 1, 1);
    set_desc(32'h200, 1, 32'h1900, 0, 1, 1, 1);
    set_desc(32'h200, 2, 32'h1A00, 2, 0, 1, 1);
    push_seg(32'h1800, 4, 1, 1);
    d0 = done_cnt;
    pulse_kick();
    wait_quiet();
    chk(done_cnt - d0 == 2, "R6", "pulses incl. empty frame", done_cnt - d0, 2);
    chk(!flags_of(32'h200, 1)[31], "R6", "empty frame released", int'(flags_of(32'h200, 1)[31]), 0);
    set_desc(32'h200, 2, 32'h1A00, 2, 1, 1, 1);
    set_desc(32'h200, 3, 32'h1B01, 3, 1, 1, 0);
    set_desc(32'h200, 0, 32'h1C02, 2, 1, 0, 1);
    push_seg(32'h1A00, 2, 1, 1);
    push_seg(32'h1B01, 3, 1, 0);
    push_seg(32'h1C02, 2, 0, 1);
    d0 = done_cnt;
    pulse_kick();
    wait_quiet();
    chk(done_cnt - d0 == 2, "R8", "frames after carry-over", done_cnt - d0, 2);
    chk(exp_q.size() == 0, "R8", "wrapped bytes unsent", exp_q.size(), 0);
    chk(!flags_of(32'h200, 0)[31], "R8", "wrapped entry 0 owned", int'(flags_of(32'h200, 0)[31]), 0);
    chk(!flags_of(32'h200, 3)[31], "R8", "entry 3 owned", int'(flags_of(32'h200, 3)[31]), 0);

    // R7: underflow
    pulse_stop();
    ring_base = 32'h300;
    set_desc(32'h300, 0, 32'h1D00, 4, 1, 1, 0);
    set_desc(32'h300, 1, 32'h1E00, 4, 0, 0, 1);
    d0 = done_cnt; u0 = uf_cnt;
    pulse_kick();
    wait_quiet();
    chk(uf_cnt - u0 == 1, "R7", "underflow pulses", uf_cnt - u0, 1);
    chk(done_cnt == d0, "R7", "tx_done on underflow", done_cnt - d0, 0);
    chk(flags_of(32'h300, 0)[31], "R7", "opening descriptor kept", int'(flags_of(32'h300, 0)[31]), 1);

    // R9: scan cap
    pulse_stop();
    ring_base = 32'h400; ring_log2 = 4'd5;
    for (int i = 0; i < 32; i++) set_desc(32'h400, i, 32'h2000 + 16 * i, 3, i < 20, 1, 1);
    for (int i = 0; i < 20; i++) push_seg(32'h2000 + 16 * i, 3, 1, 1);
    d0 = done_cnt;
    pulse_kick();
    wait_quiet();
    chk(done_cnt - d0 == 16, "R9", "frames in first scan", done_cnt - d0, 16);
    chk(exp_q.size() == 12, "R9", "bytes awaiting second scan", exp_q.size(), 12);
    pulse_kick();
    wait_quiet();
    chk(done_cnt - d0 == 20, "R9", "frames after second scan", done_cnt - d0, 20);
    chk(!flags_of(32'h400, 19)[31], "R9", "entry 19 owned", int'(flags_of(32'h400, 19)[31]), 0);

    // R10: truncation
    pulse_stop();
    ring_base = 32'h700; ring_log2 = 4'd1;
    set_desc(32'h700, 0, 32'h1003, 2100, 1, 1, 1);
    set_desc(32'h700, 1, 32'h1000, 4, 0, 1, 1);
    push_seg(32'h1003, 2048, 1, 1);
    d0 = done_cnt;
    pulse_kick();
    wait_quiet();
    chk(done_cnt - d0 == 1, "R10", "truncated frame completes", done_cnt - d0, 1);
    chk(exp_q.size() == 0, "R10", "truncated bytes unsent", exp_q.size(), 0);

    // R11: stop while streaming, then restart from entry 0
    ready_mode = 2;
    pulse_stop();
    ring_base = 32'h800; ring_log2 = 4'd2;
    set_desc(32'h800, 0, 32'h3000, 3, 1, 1, 1);
    set_desc(32'h800, 1, 32'h3100, 2, 1, 1, 1);
    set_desc(32'h800, 2, 32'h3200, 2, 0, 1, 1);
    d0 = done_cnt;
    pulse_kick();
    for (int i = 0; i < 200 && !out_valid; i++) @(negedge clk);
    chk(out_valid, "R11", "stream pending before stop", int'(out_valid), 1);
    pulse_stop();
    @(negedge clk);
    chk(!out_valid && !mem_req, "R11", "busy after stop", int'({out_valid, mem_req}), 0);
    chk(flags_of(32'h800, 0)[31], "R11", "aborted frame kept", int'(flags_of(32'h800, 0)[31]), 1);
    ready_mode = 1;
    push_seg(32'h3000, 3, 1, 1);
    push_seg(32'h3100, 2, 1, 1);
    pulse_kick();
    wait_quiet();
    chk(done_cnt - d0 == 2, "R11", "frames after restart", done_cnt - d0, 2);
    chk(exp_q.size() == 0 && !flags_of(32'h800, 0)[31], "R11", "restart from entry 0",
        exp_q.size() + int'(flags_of(32'h800, 0)[31]), 0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule